// File: doc/BRIEF.md
# Unaligned Word Load/Store Merge Unit

This block does the data merge for the partial-word "left" and "right" load and store operations. A pair of these operations moves a 32-bit word that is not naturally aligned. Each operation works on one aligned memory word. The low bits of the effective address give a byte offset. From that offset the block derives shift amounts and masks, then combines the selected bytes of the memory word with the selected bytes of the register.

For a load, the result is the new register value. For a store, the result is the new memory word together with a per-lane byte-enable mask that marks the lanes actually written. The lane convention is fixed: lane i is bits [8i+7:8i] of a word.

The inputs are registered once. Each accepted operation produces its result one clock later. Address generation, the memory port and run-time endianness selection belong to the surrounding pipeline.

Top module: `unaligned_merge_unit`

## Requirements
- R1: While the synchronous active-high reset is held, and on the first cycle after it, `out_valid`, `out_word` and `out_byte_en` are all zero.
- R2: An operation accepted with `in_valid` high appears on the outputs exactly one cycle later, with `out_valid` high. When `in_valid` is low, `out_valid` drops one cycle later and `out_word` and `out_byte_en` hold their previous values.
- R3: Left load (`op_sel` = 2'b00) at offset k: lanes 3-k..3 of the result take memory lanes 0..k, and the lower lanes keep the register's lanes.
- R4: Right load (`op_sel` = 2'b01) at offset k: result lanes 0..3-k take memory lanes k..3, and the top k lanes keep the register's lanes.
- R5: Left store (`op_sel` = 2'b10) at offset k: word lanes 0..k take register lanes 3-k..3, and the higher lanes keep the memory word.
- R6: Right store (`op_sel` = 2'b11) at offset k: word lanes k..3 take register lanes 0..3-k, and the lower lanes keep the memory word.
- R7: `out_byte_en` is zero for loads. For a left store at offset k, it sets exactly lanes 0..k. For a right store, it sets exactly lanes k..3. Every lane that is not enabled carries the unchanged memory byte.
- R8: All four offsets are legal. A left load at offset 3 or a right load at offset 0 returns the whole memory word. A left store at offset 3 or a right store at offset 0 returns the whole register with all lanes enabled.
- R9: A right load at address A followed by a left load at A+3, fed with the aligned words that hold those addresses, yields the full word that starts at A. This holds for all four offsets of A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 2 | 00 left load, 01 right load, 10 left store, 11 right store |
| byte_off | input | 2 | Low address bits, the byte offset in the aligned word |
| mem_word | input | 32 | Aligned memory word |
| reg_word | input | 32 | Current register value |
| out_valid | output | 1 | Result present |
| out_word | output | 32 | New register value (loads) or new memory word (stores) |
| out_byte_en | output | 4 | Lanes written by a store, zero for loads |

## Verification
The in-RTL properties take for granted that `op_sel`, `byte_off` and both data words are known (no X) whenever `in_valid` is high, and that reset is driven from time zero. They relate each registered output to the inputs one cycle earlier. The bench drives every input at the falling edge from fully defined values and asserts reset before the first rising edge. It returns `in_valid` to zero between bursts, so the hold behaviour under an idle input is also covered.

// File: rtl/umu_pkg.sv
package umu_pkg;
  typedef enum logic [1:0] {
    MRG_LOAD_LEFT   = 2'b00,
    MRG_LOAD_RIGHT  = 2'b01,
    MRG_STORE_LEFT  = 2'b10,
    MRG_STORE_RIGHT = 2'b11
  } merge_op_e;

  function automatic logic op_is_store(input merge_op_e op);
    return op[1];
  endfunction
endpackage

// File: rtl/umu_shift_calc.sv
// Converts a byte offset into the two bit-shift amounts used by the merges.
module umu_shift_calc #(
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = 8,
  localparam int OFFW      = $clog2(WORD_BYTES),
  localparam int SHW       = $clog2(WORD_BYTES * BYTE_W)
) (
  input  logic [OFFW-1:0] byte_off,
  output logic [SHW-1:0]  sh_left,   // (bytes-1-offset) * byte width
  output logic [SHW-1:0]  sh_right   // offset * byte width
);
  always_comb begin
    sh_left  = SHW'(((WORD_BYTES - 1) - int'(byte_off)) * BYTE_W);
    sh_right = SHW'(int'(byte_off) * BYTE_W);
  end
endmodule

// File: rtl/umu_load_merge.sv
// Register-side merge for the left and right partial loads.
module umu_load_merge #(
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = 8,
  localparam int W         = WORD_BYTES * BYTE_W,
  localparam int SHW       = $clog2(W)
) (
  input  logic           right_sel,
  input  logic [SHW-1:0] sh_left,
  input  logic [SHW-1:0] sh_right,
  input  logic [W-1:0]   mem_word,
  input  logic [W-1:0]   reg_word,
  output logic [W-1:0]   merged
);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] left_res, right_res;

  always_comb begin
    // memory moves up; register bits below the shift point survive
    left_res  = (mem_word << sh_left) | (reg_word & ~(ONES << sh_left));
    // memory moves down; register bits above the shift point survive
    right_res = (mem_word >> sh_right) | (reg_word & ~(ONES >> sh_right));
    merged    = right_sel ? right_res : left_res;
  end
endmodule

// File: rtl/umu_store_merge.sv
// Memory-side merge and lane enables for the left and right partial stores.
module umu_store_merge #(
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = 8,
  localparam int W         = WORD_BYTES * BYTE_W,
  localparam int SHW       = $clog2(W),
  localparam int OFFW      = $clog2(WORD_BYTES)
) (
  input  logic                  right_sel,
  input  logic [OFFW-1:0]       byte_off,
  input  logic [SHW-1:0]        sh_left,
  input  logic [SHW-1:0]        sh_right,
  input  logic [W-1:0]          mem_word,
  input  logic [W-1:0]          reg_word,
  output logic [W-1:0]          merged,
  output logic [WORD_BYTES-1:0] lane_en
);
  localparam logic [W-1:0]          ONES  = '1;
  localparam logic [WORD_BYTES-1:0] LONES = '1;

  logic [W-1:0]          left_res, right_res;
  logic [WORD_BYTES-1:0] left_en, right_en;
  logic [OFFW:0]         off_plus;

  always_comb begin
    off_plus  = {1'b0, byte_off} + 1'b1;
    // register moves down into the low lanes; upper memory kept
    left_res  = (reg_word >> sh_left) | (mem_word & ~(ONES >> sh_left));
    // register moves up into the high lanes; lower memory kept
    right_res = (reg_word << sh_right) | (mem_word & ~(ONES << sh_right));
    left_en   = ~(LONES << off_plus);
    right_en  = LONES << byte_off;
    merged    = right_sel ? right_res : left_res;
    lane_en   = right_sel ? right_en : left_en;
  end
endmodule

// File: rtl/unaligned_merge_unit.sv
module unaligned_merge_unit #(
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic [1:0]                      op_sel,
  input  logic [$clog2(WORD_BYTES)-1:0]   byte_off,
  input  logic [WORD_BYTES*BYTE_W-1:0]    mem_word,
  input  logic [WORD_BYTES*BYTE_W-1:0]    reg_word,
  output logic                            out_valid,
  output logic [WORD_BYTES*BYTE_W-1:0]    out_word,
  output logic [WORD_BYTES-1:0]           out_byte_en
);
  import umu_pkg::*;

  localparam int W    = WORD_BYTES * BYTE_W;
  localparam int SHW  = $clog2(W);
  localparam int OFFW = $clog2(WORD_BYTES);

  merge_op_e             op;
  logic [SHW-1:0]        sh_left, sh_right;
  logic [W-1:0]          load_res, store_res, next_word;
  logic [WORD_BYTES-1:0] store_en, next_en;

  assign op = merge_op_e'(op_sel);

  umu_shift_calc #(.WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) u_shift (
    .byte_off (byte_off),
    .sh_left  (sh_left),
    .sh_right (sh_right)
  );

  umu_load_merge #(.WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) u_load (
    .right_sel (op == MRG_LOAD_RIGHT),
    .sh_left   (sh_left),
    .sh_right  (sh_right),
    .mem_word  (mem_word),
    .reg_word  (reg_word),
    .merged    (load_res)
  );

  umu_store_merge #(.WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) u_store (
    .right_sel (op == MRG_STORE_RIGHT),
    .byte_off  (byte_off),
    .sh_left   (sh_left),
    .sh_right  (sh_right),
    .mem_word  (mem_word),
    .reg_word  (reg_word),
    .merged    (store_res),
    .lane_en   (store_en)
  );

  always_comb begin
    next_word = op_is_store(op) ? store_res : load_res;
    next_en   = op_is_store(op) ? store_en  : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_byte_en <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word    <= next_word;
        out_byte_en <= next_en;
      end
    end
  end

  // ---------------- assertions ----------------
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_byte_en)));

  a_r7_load_no_lanes: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_sel[1]) |=> (out_byte_en == '0));

  a_r7_left_store_count: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b10) |=>
      (out_byte_en[0] && $countones(out_byte_en) == int'($past(byte_off)) + 1));

  a_r7_right_store_count: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b11) |=>
      (out_byte_en[WORD_BYTES-1] &&
       $countones(out_byte_en) == WORD_BYTES - int'($past(byte_off))));

  a_r8_left_load_full: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b00 && byte_off == OFFW'(WORD_BYTES-1)) |=>
      (out_word == $past(mem_word)));

  a_r8_right_load_full: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b01 && byte_off == '0) |=>
      (out_word == $past(mem_word)));

  generate
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane_chk
      a_r7_unwritten_lane_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel[1]) |=>
          (out_byte_en[g] ||
           out_word[g*BYTE_W +: BYTE_W] == $past(mem_word[g*BYTE_W +: BYTE_W])));
    end
  endgenerate
endmodule

// File: tb/unaligned_merge_unit_test.sv
module unaligned_merge_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [1:0]  byte_off = 2'b00;
  logic [31:0] mem_word = '0;
  logic [31:0] reg_word = '0;
  logic        out_valid;
  logic [31:0] out_word;
  logic [3:0]  out_byte_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] word;
    logic [3:0]  en;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  logic [31:0] last_word;
  logic [3:0]  last_en;

  always #2 clk = ~clk;

  unaligned_merge_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .byte_off(byte_off), .mem_word(mem_word), .reg_word(reg_word),
    .out_valid(out_valid), .out_word(out_word), .out_byte_en(out_byte_en)
  );

  // Lane-by-lane reference, written from the requirement text.
  function automatic logic [31:0] ref_word(input logic [1:0] op, input int k,
                                           input logic [31:0] m, input logic [31:0] r);
    logic [31:0] res;
    for (int i = 0; i < 4; i++) begin
      case (op)
        2'b00: res[8*i +: 8] = (i >= 3-k) ? m[8*(i-(3-k)) +: 8] : r[8*i +: 8];
        2'b01: res[8*i +: 8] = (i <= 3-k) ? m[8*(i+k) +: 8]     : r[8*i +: 8];
        2'b10: res[8*i +: 8] = (i <= k)   ? r[8*(i+3-k) +: 8]   : m[8*i +: 8];
        default: res[8*i +: 8] = (i >= k) ? r[8*(i-k) +: 8]     : m[8*i +: 8];
      endcase
    end
    return res;
  endfunction

  function automatic logic [3:0] ref_en(input logic [1:0] op, input int k);
    logic [3:0] e;
    for (int i = 0; i < 4; i++) begin
      case (op)
        2'b10: e[i] = (i <= k);
        2'b11: e[i] = (i >= k);
        default: e[i] = 1'b0;
      endcase
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [35:0] act,
                       input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one operation per call, expected result into the scoreboard.
  task automatic issue(input logic [1:0] op, input int k, input logic [31:0] m,
                       input logic [31:0] r, input logic [31:0] exp_word, input string tag);
    exp_t e;
    e.word = exp_word;
    e.en   = ref_en(op, k);
    e.tag  = tag;
    @(negedge clk);
    sb_q.push_back(e);
    in_valid = 1'b1; op_sel = op; byte_off = 2'(k); mem_word = m; reg_word = r;
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: pops and compares as results appear.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && out_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2 unexpected result", {out_byte_en, out_word}, '0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(out_word == e.word, e.tag, {4'h0, out_word}, {4'h0, e.word});
          check(out_byte_en == e.en, {e.tag, " R7 lanes"}, {32'h0, out_byte_en}, {32'h0, e.en});
          last_word = e.word;
          last_en   = e.en;
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    logic [31:0] pats_m[4];
    logic [31:0] pats_r[4];
    pats_m = '{32'h44332211, 32'hFFFFFFFF, 32'h00000000, 32'hA5C3E187};
    pats_r = '{32'hDDCCBBAA, 32'h00000000, 32'hFFFFFFFF, 32'h5A3C1E78};

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0 && out_word == '0 && out_byte_en == '0, "R1 reset",
          {out_byte_en, out_word}, '0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(out_valid == 1'b0 && out_word == '0 && out_byte_en == '0, "R1 after reset",
          {out_byte_en, out_word}, '0);

    // R3..R6, R8: every operation at every offset over several patterns
    for (int p = 0; p < 4; p++) begin
      for (int op = 0; op < 4; op++) begin
        for (int k = 0; k < 4; k++) begin
          string t;
          case (op)
            0: t = (k == 3) ? "R8 R3 left load" : "R3 left load";
            1: t = (k == 0) ? "R8 R4 right load" : "R4 right load";
            2: t = (k == 3) ? "R8 R5 left store" : "R5 left store";
            default: t = (k == 0) ? "R8 R6 right store" : "R6 right store";
          endcase
          issue(2'(op), k, pats_m[p], pats_r[p], ref_word(2'(op), k, pats_m[p], pats_r[p]), t);
        end
      end
      go_idle();
    end

    // R9: right load at A then left load at A+3 rebuild the word at A
    for (int k = 0; k < 4; k++) begin
      logic [31:0] m0, m1, r1, whole;
      logic [63:0] both;
      m0 = 32'h13579BDF + 32'(k);
      m1 = 32'h2468ACE0 ^ 32'(k << 8);
      both  = {m1, m0};
      whole = both[8*k +: 32];
      r1 = ref_word(2'b01, k, m0, 32'hCAFEF00D);
      issue(2'b01, k, m0, 32'hCAFEF00D, r1, "R9 pair first half");
      issue(2'b00, (k + 3) % 4, (k == 0) ? m0 : m1, r1, whole, "R9 pair rebuilt word");
    end
    go_idle();

    // R2: idle input must not disturb the outputs
    wait (sb_q.size() == 0);
    @(negedge clk);
    in_valid = 1'b0; mem_word = 32'h0BADBEEF; reg_word = 32'h12345678; op_sel = 2'b11;
    repeat (2) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R2 valid drops", {35'h0, out_valid}, '0);
    check(out_word == last_word && out_byte_en == last_en, "R2 hold while idle",
          {out_byte_en, out_word}, {last_en, last_word});

    repeat (3) @(posedge clk);
    check(sb_q.size() == 0, "R2 all results returned", 36'(sb_q.size()), '0);
    finish_run();
  end
endmodule